// File: doc/BRIEF.md
# Mode-Selectable Video Pixel Serializer

This block turns bytes fetched from display memory into a stream of logical colour indices. It runs on the fastest pixel clock and takes one byte per display access. Each byte covers eight clock cycles of screen time. The bit depth per pixel follows a mode select: eight 1-bit pixels, four 2-bit pixels, or two 4-bit pixels. The same byte and the same shift path are used in every mode, so a finer picture with few colours and a coarser picture with more colours take the same memory bandwidth.

A display memory controller pulses the byte strobe once per access, with the byte on the data input. The serializer emits the pixels most significant first. Each pixel is held for as many cycles as it has bits, which keeps one byte at a fixed eight-cycle span in every mode. A palette stage downstream turns the index into a colour. Display enable blanks the index to zero outside the active picture.

Top module: `pixel_serializer`

## Requirements
- R1: While reset is asserted and after its release with no strobe, pix_valid is 0 and pix_index is 0.
- R2: A strobe is accepted when the serializer is idle or in the last cycle of a byte. From the next cycle, pix_valid is 1 and the first pixel of the new byte is shown.
- R3: Mode code 0 (1 bit per pixel) shows the byte as eight pixels, bit 7 first down to bit 0, one cycle each.
- R4: Mode code 1 (2 bits per pixel) shows four pixels, bits [7:6] first, then [5:4], [3:2], [1:0], each held two cycles.
- R5: Mode codes 2 and 3 (4 bits per pixel) show two pixels, bits [7:4] then [3:0], each held four cycles.
- R6: Each accepted byte spans exactly eight cycles. With no new strobe, pix_valid returns to 0 after them.
- R7: A strobe that arrives while a byte is still shifting, other than in its last cycle, is ignored. The pixels of the current byte continue unchanged.
- R8: A change of mode_sel takes effect only at the next accepted strobe.
- R9: When disp_en is 0, pix_index is 0. pix_valid is not affected.
- R10: In the 1- and 2-bit modes, the pixel sits in the low bits of pix_index and the upper bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (one cycle per finest pixel) |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_stb | input | 1 | Byte strobe from the display fetch |
| byte_data | input | BYTE_W | Byte read from display memory |
| mode_sel | input | 2 | Bits per pixel: 0 = 1, 1 = 2, 2 or 3 = 4 |
| disp_en | input | 1 | Display enable; low blanks the index |
| pix_index | output | PIX_W | Logical colour index |
| pix_valid | output | 1 | A byte is being shifted out |

## Verification
The bench builds the block with its defaults: an 8-bit byte and a 4-bit index. At this size every byte value can be sent in every mode code, so every pixel position of every pattern is compared with a value computed from shifts and masks. Back-to-back bytes exercise acceptance in the last cycle. Directed cases cover a strobe ignored in mid-byte, a mode change during a byte, blanking, and the drop of pix_valid after an unfollowed byte.

// File: rtl/vser_pkg.sv
package vser_pkg;

  typedef enum logic [1:0] {
    MODE_1BPP = 2'd0,
    MODE_2BPP = 2'd1,
    MODE_4BPP = 2'd2,
    MODE_4ALT = 2'd3
  } depth_mode_t;

  // Bits per pixel for a mode code; this is also the hold length in cycles
  function automatic int unsigned bits_per_pixel(input logic [1:0] m);
    case (m)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/vser_timing.sv
module vser_timing
  import vser_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 4,
  parameter int PH_W   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_i,
  input  logic [1:0] mode_i,
  output logic       load_o,
  output logic       shift_o,
  output logic       active_o,
  output logic [1:0] mode_o
);

  logic [CNT_W-1:0] tcnt;
  logic [PH_W-1:0]  ph;
  logic [1:0]       mode_q;
  logic [PH_W-1:0]  hold_last;
  logic             last_cycle;

  assign hold_last  = PH_W'(bits_per_pixel(mode_q) - 1);
  assign active_o   = (tcnt != '0);
  assign last_cycle = (tcnt == CNT_W'(1));
  assign load_o     = strobe_i && (!active_o || last_cycle);
  assign shift_o    = active_o && !load_o && (ph == hold_last);
  assign mode_o     = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt   <= '0;
      ph     <= '0;
      mode_q <= MODE_1BPP;
    end else if (load_o) begin
      tcnt   <= CNT_W'(BYTE_W);
      ph     <= '0;
      mode_q <= mode_i;
    end else if (active_o) begin
      tcnt <= tcnt - CNT_W'(1);
      ph   <= (ph == hold_last) ? '0 : ph + PH_W'(1);
    end
  end

  assert_load_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (tcnt == CNT_W'(BYTE_W) && ph == '0));

  assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && tcnt > CNT_W'(1)) |=> (tcnt == $past(tcnt) - CNT_W'(1)));

  assert_span_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_cycle && !strobe_i) |=> !active_o);

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_o |=> $stable(mode_q));

endmodule

// File: rtl/vser_shifter.sv
module vser_shifter
  import vser_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [1:0]        mode_i,
  output logic [BYTE_W-1:0] shreg_o
);

  logic [BYTE_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n)
      shreg <= '0;
    else if (load_i)
      shreg <= data_i;
    else if (shift_i)
      shreg <= shreg << bits_per_pixel(mode_i);
  end

  assign shreg_o = shreg;

endmodule

// File: rtl/vser_outmux.sv
module vser_outmux
  import vser_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PIX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] shreg_i,
  input  logic [1:0]        mode_i,
  input  logic              active_i,
  input  logic              de_i,
  output logic [PIX_W-1:0]  pixel_o
);

  // Top bpp bits of the shift register, right-aligned
  function automatic logic [PIX_W-1:0] top_field(input logic [BYTE_W-1:0] s,
                                                 input int unsigned bpp);
    logic [BYTE_W-1:0] t;
    t = s >> (BYTE_W - bpp);
    t = t & ((BYTE_W'(1) << bpp) - BYTE_W'(1));
    return PIX_W'(t);
  endfunction

  assign pixel_o = (de_i && active_i) ? top_field(shreg_i, bits_per_pixel(mode_i)) : '0;

  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_1BPP) |-> (pixel_o[PIX_W-1:1] == '0));

  assert_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !de_i |-> (pixel_o == '0));

endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
  import vser_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PIX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [1:0]        mode_sel,
  input  logic              disp_en,
  output logic [PIX_W-1:0]  pix_index,
  output logic              pix_valid
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int PH_W  = (PIX_W > 1) ? $clog2(PIX_W) : 1;

  logic              load_w;
  logic              shift_w;
  logic              active_w;
  logic [1:0]        mode_w;
  logic [BYTE_W-1:0] shreg_w;

  vser_timing #(.BYTE_W(BYTE_W), .CNT_W(CNT_W), .PH_W(PH_W)) u_timing (
    .clk(clk), .rst_n(rst_n), .strobe_i(byte_stb), .mode_i(mode_sel),
    .load_o(load_w), .shift_o(shift_w), .active_o(active_w), .mode_o(mode_w)
  );

  vser_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(load_w), .shift_i(shift_w),
    .data_i(byte_data), .mode_i(mode_w), .shreg_o(shreg_w)
  );

  vser_outmux #(.BYTE_W(BYTE_W), .PIX_W(PIX_W)) u_out (
    .clk(clk), .rst_n(rst_n), .shreg_i(shreg_w), .mode_i(mode_w),
    .active_i(active_w), .de_i(disp_en), .pixel_o(pix_index)
  );

  assign pix_valid = active_w;

  assert_shift_needs_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_w |-> (active_w && !load_w));

endmodule

// File: tb/pixel_serializer_test.sv
module pixel_serializer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_stb = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic [1:0] mode_sel = 2'd0;
  logic       disp_en = 1'b1;
  logic [3:0] pix_index;
  logic       pix_valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pixel_serializer uut (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_data(byte_data),
    .mode_sel(mode_sel), .disp_en(disp_en), .pix_index(pix_index), .pix_valid(pix_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_pix(input int d, input int m, input int t, input bit en);
    int w;
    int k;
    w = (m == 0) ? 1 : (m == 1) ? 2 : 4;
    k = t / w;
    if (!en) return 0;
    return (d / (1 << (8 - w * (k + 1)))) % (1 << w);
  endfunction

  // Called at a negedge. Drives one byte, then checks its eight pixels.
  // inj: cycle at which a stray strobe is raised (-1 none)
  // chg: cycle at which mode_sel is changed to nm (-1 none)
  task automatic send(input int d, input int m, input bit en,
                      input int inj, input int chg, input int nm, input string req);
    byte_stb  = 1'b1;
    byte_data = 8'(d);
    mode_sel  = 2'(m);
    disp_en   = en;
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      byte_stb = 1'b0;
      chk(pix_valid == 1'b1, "R2 valid after accepted strobe", int'(pix_valid), 1);
      chk(int'(pix_index) == expect_pix(d, m, t, en), req,
          int'(pix_index), expect_pix(d, m, t, en));
      if (t == inj) begin
        byte_stb  = 1'b1;
        byte_data = ~8'(d);
      end
      if (t == chg) mode_sel = 2'(nm);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pix_valid == 1'b0, "R1 valid in reset", int'(pix_valid), 0);
    chk(pix_index == 4'd0, "R1 index in reset", int'(pix_index), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(pix_valid == 1'b0, "R1 valid idle after reset", int'(pix_valid), 0);
    chk(pix_index == 4'd0, "R1 index idle after reset", int'(pix_index), 0);

    // Exhaustive sweep, back-to-back bytes
    for (int d = 0; d < 256; d++) send(d, 0, 1'b1, -1, -1, 0, "R3 1bpp pixel (R10 upper zero)");
    for (int d = 0; d < 256; d++) send(d, 1, 1'b1, -1, -1, 0, "R4 2bpp pixel (R10 upper zero)");
    for (int d = 0; d < 256; d++) send(d, 2, 1'b1, -1, -1, 0, "R5 4bpp pixel");
    for (int d = 0; d < 256; d += 7) send(d, 3, 1'b1, -1, -1, 0, "R5 mode code 3 pixel");

    // Unfollowed byte: valid drops
    @(negedge clk);
    chk(pix_valid == 1'b0, "R6 valid drops after 8 cycles", int'(pix_valid), 0);
    chk(pix_index == 4'd0, "R6 index idle", int'(pix_index), 0);
    @(negedge clk);

    // Blanking in every mode
    send(8'hFF, 0, 1'b0, -1, -1, 0, "R9 blank 1bpp");
    send(8'hFF, 1, 1'b0, -1, -1, 0, "R9 blank 2bpp");
    send(8'hFF, 2, 1'b0, -1, -1, 0, "R9 blank 4bpp");

    // Stray strobes mid-byte are ignored
    for (int s = 0; s < 7; s++) send(8'hC6, 0, 1'b1, s, -1, 0, "R7 stray strobe ignored");
    send(8'h3A, 2, 1'b1, 2, -1, 0, "R7 stray strobe ignored 4bpp");

    // Mode change mid-byte takes effect at next load
    send(8'hA5, 2, 1'b1, -1, 1, 0, "R8 mode held during byte");
    send(8'hA5, 0, 1'b1, -1, 3, 1, "R8 new mode at next load");
    send(8'hB4, 1, 1'b1, -1, 0, 2, "R8 mode held 2bpp");
    @(negedge clk);
    chk(pix_valid == 1'b0, "R6 valid drops at end", int'(pix_valid), 0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule